// File: doc/BRIEF.md
# Dynamic Phase Aligner with Resynchronizing FIFO

The block recovers a serial bit stream whose phase against the local fast clock is unknown. Every bit period it receives eight samples of the line, taken at eight equally spaced phases, as a tap vector. Over each fixed window it records which taps saw a data transition. At the end of the window it picks the tap that lies farthest from those transitions, which is the sample nearest the centre of the data eye.

Once the same tap has won a programmable number of windows in a row, the aligner declares lock and freezes its choice. Until lock, the selected phase may still move, so the bridge FIFO is held empty. After lock, the bit from the chosen tap is written into the FIFO on the sampling clock. The FIFO uses Gray-coded pointers. The reference fast clock reads it out as a serial stream with a valid flag, ready for a deserializer. A write into a full FIFO, or a starved read after streaming has begun, raises a sticky error.

Top module: `dpa_aligner`

## Requirements
- R1: Tap k (0..7) registers a transition in a cycle when its value differs from tap k-1 of the same cycle; for tap 0 the comparison is with tap 7 of the previous cycle. No transitions are recorded in the first sampled cycle after reset.
- R2: At the end of every window of WIN_LEN sampled cycles, the candidate becomes the tap with the largest circular distance (modulo 8) to the nearest tap that saw a transition in that window. Ties go to the lowest index. A window without transitions selects tap 0. `phase_o` shows the candidate and changes only at a window end.
- R3: `lock_o` rises at the end of the window that completes LOCK_WINS consecutive identical choices. With a steady input it is low after sampling edge WIN_LEN*LOCK_WINS-1 following reset release and high after edge WIN_LEN*LOCK_WINS.
- R4: Once locked, `phase_o` no longer changes and `lock_o` stays high whatever the input does; only `rst_i` clears it.
- R5: Before lock the FIFO is held empty and receives no writes, and `ser_vld_o` stays low.
- R6: After lock, each sampling cycle writes the value of the selected tap. `ser_o` then delivers these bits in their original order, so the output is a contiguous run of the transmitted bit sequence.
- R7: Reading begins once the read side sees at least START_LVL stored entries. From then on, with both clocks at the same rate, `ser_vld_o` is high on every reference cycle.
- R8: A write attempted into a full FIFO, or an empty FIFO on the read side after streaming has begun, sets `err_o`. `err_o` then stays high until reset and is low during normal streaming.
- R9: While `rst_i` is high, `lock_o`, `phase_o`, `ser_vld_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| samp_clk_i | input | 1 | Sampling clock, one rising edge per bit period; also the FIFO write clock |
| ref_clk_i | input | 1 | Reference fast clock; FIFO read clock |
| rst_i | input | 1 | Asynchronous active-high reset for both domains |
| tap_i | input | NTAP (8) | Line samples at the eight phases; bit k is phase k, lower index is earlier in the bit period |
| lock_o | output | 1 | Phase choice settled (sampling domain) |
| phase_o | output | 3 | Candidate or chosen tap index |
| ser_o | output | 1 | Retimed serial data (reference domain) |
| ser_vld_o | output | 1 | `ser_o` carries a bit this cycle |
| err_o | output | 1 | Sticky FIFO overflow or underflow flag (reference domain) |

## Verification
The error flag is the hardest state to reach. With the two clocks at the same rate, the FIFO level stays constant, so neither overflow nor underflow can happen through the data ports. To reach it, the bench gates its own clocks once streaming has settled. Holding the reference clock for forty bit periods fills the FIFO until a write is refused. Holding the sampling clock starves the reader. In both cases the bench checks that the flag appears and then stays set. The exact lock cycle is also checked, which requires the first sampled cycle after reset to be kept from producing a false tap-0 transition.

// File: rtl/dpa_pkg.sv
`timescale 1ns/1ps
package dpa_pkg;

  // Read-side sequencing of the resync FIFO.
  typedef enum logic [1:0] {RD_IDLE, RD_FILL, RD_STREAM} rd_state_e;

  // Distance between two taps on a ring of n phases.
  function automatic int circ_dist(input int a, input int b, input int n);
    int d;
    d = (a > b) ? a - b : b - a;
    return (d > n - d) ? n - d : d;
  endfunction

endpackage

// File: rtl/dpa_phase_pick.sv
`timescale 1ns/1ps
module dpa_phase_pick #(
  parameter int NTAP      = 8,
  parameter int WIN_LEN   = 32,
  parameter int LOCK_WINS = 4,
  localparam int PW = $clog2(NTAP)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NTAP-1:0] tap_i,
  output logic            lock_o,
  output logic [PW-1:0]   phase_o,
  output logic            bit_o
);
  localparam int CW = $clog2(WIN_LEN);
  localparam int RW = $clog2(LOCK_WINS + 1);

  logic            prev_last, primed, locked, win_end;
  logic [NTAP-1:0] edge_now, edge_seen, edge_all;
  logic [CW-1:0]   win_cnt;
  logic [PW-1:0]   cand, pick;
  logic [RW-1:0]   run, run_next;

  // Tap farthest from every transition; strict compare keeps the lowest index.
  function automatic logic [PW-1:0] best_tap(input logic [NTAP-1:0] ev);
    logic [PW-1:0] sel;
    int best_d, near, d;
    sel = '0;
    best_d = -1;
    for (int j = 0; j < NTAP; j++) begin
      near = NTAP;
      for (int k = 0; k < NTAP; k++)
        if (ev[k]) begin
          d = dpa_pkg::circ_dist(j, k, NTAP);
          if (d < near) near = d;
        end
      if (near > best_d) begin
        best_d = near;
        sel = PW'(j);
      end
    end
    return sel;
  endfunction

  // Transition detectors: tap 0 looks back at the last tap of the previous bit.
  for (genvar k = 0; k < NTAP; k++) begin : g_edge
    if (k == 0) begin : g_wrap
      assign edge_now[k] = primed & (tap_i[k] ^ prev_last);
    end else begin : g_inner
      assign edge_now[k] = tap_i[k] ^ tap_i[k-1];
    end
  end

  assign edge_all = edge_seen | edge_now;
  assign pick     = best_tap(edge_all);
  assign win_end  = (win_cnt == CW'(WIN_LEN - 1));
  assign run_next = (run != '0 && pick == cand) ? run + RW'(1) : RW'(1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prev_last <= 1'b0;
      primed    <= 1'b0;
      win_cnt   <= '0;
      edge_seen <= '0;
      cand      <= '0;
      run       <= '0;
      locked    <= 1'b0;
    end else begin
      prev_last <= tap_i[NTAP-1];
      primed    <= 1'b1;
      if (win_end) begin
        win_cnt   <= '0;
        edge_seen <= '0;
      end else begin
        win_cnt   <= win_cnt + CW'(1);
        edge_seen <= edge_all;
      end
      if (win_end && !locked) begin
        cand <= pick;
        run  <= run_next;
        if (run_next == RW'(LOCK_WINS)) locked <= 1'b1;
      end
    end
  end

  assign lock_o  = locked;
  assign phase_o = cand;
  assign bit_o   = tap_i[cand];

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);
  // R4
  phase_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(cand));
  // R2
  phase_window_chk: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(cand));
  // R3
  lock_at_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(win_end));

endmodule

// File: rtl/dpa_resync_fifo.sv
`timescale 1ns/1ps
module dpa_resync_fifo #(
  parameter int DEPTH     = 16,
  parameter int START_LVL = 4
) (
  input  logic wclk,
  input  logic rclk,
  input  logic rst,
  input  logic wr_arm,
  input  logic wdata,
  output logic rd_data_o,
  output logic rd_vld_o,
  output logic err_o
);
  import dpa_pkg::*;

  localparam int AW   = $clog2(DEPTH);
  localparam int PTRW = AW + 1;

  function automatic logic [PTRW-1:0] bin2gray(input logic [PTRW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTRW-1:0] gray2bin(input logic [PTRW-1:0] g);
    logic [PTRW-1:0] b;
    b[PTRW-1] = g[PTRW-1];
    for (int i = PTRW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DEPTH-1:0] mem;
  logic [PTRW-1:0]  wbin, wbin_next, wgray, rg_w1, rg_w2, occ_w;
  logic [PTRW-1:0]  rbin, rbin_next, rgray, wg_r1, wg_r2, occ_r;
  logic             full_w, push, ovf_w;
  logic             arm_r1, arm_r2, ovf_r1, ovf_r2;
  logic             pop, starve, data_q, vld_q, undf_q;
  rd_state_e        rstate;

  // ---------------- write side (selected sampling phase) ----------------
  assign occ_w     = wbin - gray2bin(rg_w2);
  assign full_w    = (occ_w == PTRW'(DEPTH));
  assign push      = wr_arm & ~full_w;
  assign wbin_next = wr_arm ? wbin + PTRW'(push) : '0;

  always_ff @(posedge wclk) begin
    if (push) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk or posedge rst) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      rg_w1 <= '0;
      rg_w2 <= '0;
      ovf_w <= 1'b0;
    end else begin
      rg_w1 <= rgray;
      rg_w2 <= rg_w1;
      wbin  <= wbin_next;
      wgray <= bin2gray(wbin_next);
      if (wr_arm && full_w) ovf_w <= 1'b1;
    end
  end

  // ---------------- read side (reference fast clock) ----------------
  assign occ_r     = gray2bin(wg_r2) - rbin;
  assign pop       = (rstate == RD_STREAM) && (occ_r != '0);
  assign starve    = (rstate == RD_STREAM) && (occ_r == '0);
  assign rbin_next = rbin + PTRW'(pop);

  always_ff @(posedge rclk or posedge rst) begin
    if (rst) begin
      arm_r1 <= 1'b0;
      arm_r2 <= 1'b0;
      wg_r1  <= '0;
      wg_r2  <= '0;
      ovf_r1 <= 1'b0;
      ovf_r2 <= 1'b0;
      rbin   <= '0;
      rgray  <= '0;
      rstate <= RD_IDLE;
      data_q <= 1'b0;
      vld_q  <= 1'b0;
      undf_q <= 1'b0;
    end else begin
      arm_r1 <= wr_arm;
      arm_r2 <= arm_r1;
      wg_r1  <= wgray;
      wg_r2  <= wg_r1;
      ovf_r1 <= ovf_w;
      ovf_r2 <= ovf_r1;
      rbin   <= rbin_next;
      rgray  <= bin2gray(rbin_next);
      vld_q  <= pop;
      if (pop) data_q <= mem[rbin[AW-1:0]];
      if (starve) undf_q <= 1'b1;
      case (rstate)
        RD_IDLE: if (arm_r2) rstate <= RD_FILL;
        RD_FILL: if (occ_r >= PTRW'(START_LVL)) rstate <= RD_STREAM;
        default: ;
      endcase
    end
  end

  assign rd_data_o = data_q;
  assign rd_vld_o  = vld_q;
  assign err_o     = undf_q | ovf_r2;

  // R5
  idle_clear_chk: assert property (@(posedge wclk) disable iff (rst)
    !wr_arm |=> (wbin == '0));
  // R5
  vld_after_arm_chk: assert property (@(posedge rclk) disable iff (rst)
    rd_vld_o |-> arm_r2);
  // R7
  vld_in_stream_chk: assert property (@(posedge rclk) disable iff (rst)
    rd_vld_o |-> (rstate == RD_STREAM));
  // R6
  pop_order_chk: assert property (@(posedge rclk) disable iff (rst)
    rd_vld_o |-> (rbin == $past(rbin) + PTRW'(1)));
  // R8
  err_sticky_chk: assert property (@(posedge rclk) disable iff (rst)
    err_o |=> err_o);

  always @(posedge wclk) begin
    if (!rst) begin
      // R8
      wr_level_chk: assert (occ_w <= PTRW'(DEPTH)) else $error("write-side level above depth");
    end
  end

  always @(posedge rclk) begin
    if (!rst) begin
      // R8
      rd_level_chk: assert (occ_r <= PTRW'(DEPTH)) else $error("read-side level above depth");
    end
  end

endmodule

// File: rtl/dpa_aligner.sv
`timescale 1ns/1ps
module dpa_aligner #(
  parameter int NTAP      = 8,
  parameter int WIN_LEN   = 32,
  parameter int LOCK_WINS = 4,
  parameter int DEPTH     = 16,
  parameter int START_LVL = 4,
  localparam int PW = $clog2(NTAP)
) (
  input  logic            samp_clk_i,
  input  logic            ref_clk_i,
  input  logic            rst_i,
  input  logic [NTAP-1:0] tap_i,
  output logic            lock_o,
  output logic [PW-1:0]   phase_o,
  output logic            ser_o,
  output logic            ser_vld_o,
  output logic            err_o
);
  logic locked, sel_bit;

  dpa_phase_pick #(
    .NTAP(NTAP), .WIN_LEN(WIN_LEN), .LOCK_WINS(LOCK_WINS)
  ) u_pick (
    .clk(samp_clk_i), .rst(rst_i), .tap_i(tap_i),
    .lock_o(locked), .phase_o(phase_o), .bit_o(sel_bit)
  );

  // Lock arms the FIFO: before it, the write side is held cleared.
  dpa_resync_fifo #(
    .DEPTH(DEPTH), .START_LVL(START_LVL)
  ) u_fifo (
    .wclk(samp_clk_i), .rclk(ref_clk_i), .rst(rst_i),
    .wr_arm(locked), .wdata(sel_bit),
    .rd_data_o(ser_o), .rd_vld_o(ser_vld_o), .err_o(err_o)
  );

  assign lock_o = locked;

endmodule

// File: tb/test_dpa_aligner.sv
`timescale 1ns/1ps
module test_dpa_aligner;
  localparam int NTAP = 8, WIN_LEN = 32, LOCK_WINS = 4, DEPTH = 16, START_LVL = 4;
  localparam int HM = 8191;

  logic samp_clk = 1'b0, ref_clk = 1'b0, rst = 1'b1;
  logic [NTAP-1:0] tap = '0;
  logic lock, ser, ser_vld, err;
  logic [2:0] phase;
  bit samp_run = 1'b1, ref_run = 1'b1, done = 1'b0;
  int n_chk = 0, n_bad = 0;
  int mode = 1, off = 0, const_val = 0;
  int n_smp = 0, oc = 0;
  logic hist [0:HM];
  logic out_bits [0:HM];
  logic [15:0] lfsr = 16'hACE1;

  dpa_aligner #(.NTAP(NTAP), .WIN_LEN(WIN_LEN), .LOCK_WINS(LOCK_WINS),
                .DEPTH(DEPTH), .START_LVL(START_LVL)) i_dpa_aligner (
    .samp_clk_i(samp_clk), .ref_clk_i(ref_clk), .rst_i(rst), .tap_i(tap),
    .lock_o(lock), .phase_o(phase), .ser_o(ser), .ser_vld_o(ser_vld), .err_o(err));

  // 125 MHz clocks, same rate, reference shifted by 3 ns; each can be held.
  initial forever begin #4; if (samp_run) samp_clk = ~samp_clk; end
  initial begin #3; forever begin #4; if (ref_run) ref_clk = ~ref_clk; end end

  // Line model: taps at index >= eff already see the new bit.
  initial forever begin
    @(negedge samp_clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    hist[n_smp & HM] = lfsr[0];
    begin
      int eff;
      logic cur, prv;
      cur = hist[n_smp & HM];
      prv = hist[(n_smp - 1) & HM];
      eff = (mode == 2) ? off + (n_smp & 1) : off;
      for (int k = 0; k < NTAP; k++)
        tap[k] = (mode == 0) ? const_val[0] : ((k >= eff) ? cur : prv);
    end
    n_smp++;
  end

  initial forever begin
    @(negedge ref_clk);
    if (ser_vld === 1'b1) begin
      out_bits[oc & HM] = ser;
      oc++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reset_dut();
    samp_run = 1'b1;
    ref_run  = 1'b1;
    rst = 1'b1;
    repeat (4) @(negedge samp_clk);
    rst = 1'b0;
  endtask

  task automatic wait_lock(output int got, output int vld_seen);
    vld_seen = 0;
    for (int i = 0; i < 2000 && lock !== 1'b1; i++) begin
      @(negedge samp_clk);
      if (ser_vld === 1'b1 && lock !== 1'b1) vld_seen = 1;
    end
    got = (lock === 1'b1) ? 1 : 0;
  endtask

  task automatic phase_case(input string req, input int m, input int o, input int exp);
    int got, vs;
    mode = m;
    off = o;
    reset_dut();
    wait_lock(got, vs);
    check(req, "lock reached", got, 1);
    check(req, "chosen phase", int'(phase), exp);
  endtask

  // R9 reset values, R3 exact lock edge, R2 centre of eye for offset 2
  task automatic t_lock_timing();
    mode = 1;
    off = 2;
    rst = 1'b1;
    repeat (3) @(negedge samp_clk);
    check("R9", "lock in reset", int'(lock), 0);
    check("R9", "phase in reset", int'(phase), 0);
    check("R9", "valid in reset", int'(ser_vld), 0);
    check("R9", "error in reset", int'(err), 0);
    rst = 1'b0;
    repeat (WIN_LEN * LOCK_WINS - 1) @(negedge samp_clk);
    check("R3", "lock one edge early", int'(lock), 0);
    @(negedge samp_clk);
    check("R3", "lock on last window edge", int'(lock), 1);
    check("R2", "phase for offset 2", int'(phase), 6);
  endtask

  // R1 wrap-around edge at tap 0, R2 other offsets, ties and idle line
  task automatic t_phase_cases();
    phase_case("R1", 1, 0, 4);
    phase_case("R2", 1, 5, 1);
    phase_case("R2", 1, 7, 3);
    phase_case("R2", 2, 4, 0);
    phase_case("R2", 2, 0, 4);
    const_val = 1;
    phase_case("R2", 0, 0, 0);
  endtask

  // R4 frozen choice and reset-only release
  task automatic t_freeze();
    phase_case("R4", 1, 3, 7);
    off = 6;
    repeat (200) @(negedge samp_clk);
    check("R4", "phase after input moved", int'(phase), 7);
    check("R4", "lock after input moved", int'(lock), 1);
    rst = 1'b1;
    @(negedge samp_clk);
    check("R4", "lock cleared by reset", int'(lock), 0);
  endtask

  // R5, R6, R7, R8 normal streaming, then R8 overflow by holding the read clock
  task automatic t_stream_and_overflow();
    int got, vs, dly, gaps, oc0, o_lo;
    bit found, ok;
    mode = 1;
    off = 1;
    reset_dut();
    wait_lock(got, vs);
    check("R5", "no valid before lock", vs, 0);
    check("R2", "phase for offset 1", int'(phase), 5);
    dly = 0;
    while (ser_vld !== 1'b1 && dly < 100) begin
      @(negedge ref_clk);
      dly++;
    end
    check("R7", "start delay in range",
          (dly >= START_LVL && dly <= START_LVL + 10) ? 1 : 0, 1);
    #1;
    oc0 = oc;
    gaps = 0;
    repeat (100) begin
      @(negedge ref_clk);
      if (ser_vld !== 1'b1) gaps++;
    end
    check("R7", "valid gaps while streaming", gaps, 0);
    found = 1'b0;
    o_lo = (n_smp > 3000) ? n_smp - 3000 : 0;
    for (int o = o_lo; o <= n_smp - 64 && !found; o++) begin
      ok = 1'b1;
      for (int i = 0; i < 64; i++)
        if (out_bits[(oc0 + i) & HM] !== hist[(o + i) & HM]) ok = 1'b0;
      if (ok) found = 1'b1;
    end
    check("R6", "output is a run of the input", int'(found), 1);
    check("R8", "no error while streaming", int'(err), 0);
    ref_run = 1'b0;
    repeat (40) @(negedge samp_clk);
    ref_run = 1'b1;
    repeat (10) @(negedge ref_clk);
    check("R8", "overflow flagged", int'(err), 1);
    repeat (30) @(negedge ref_clk);
    check("R8", "overflow flag sticky", int'(err), 1);
  endtask

  // R8 underflow by holding the sampling clock
  task automatic t_underflow();
    int got, vs;
    mode = 1;
    off = 6;
    reset_dut();
    wait_lock(got, vs);
    repeat (30) @(negedge ref_clk);
    check("R8", "no error before starving", int'(err), 0);
    samp_run = 1'b0;
    repeat (20) @(negedge ref_clk);
    check("R8", "underflow flagged", int'(err), 1);
    samp_run = 1'b1;
    repeat (20) @(negedge ref_clk);
    check("R8", "underflow flag sticky", int'(err), 1);
  endtask

  initial begin
    t_lock_timing();
    t_phase_cases();
    t_freeze();
    t_stream_and_overflow();
    t_underflow();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(150000 * 8);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule